// File: doc/BRIEF.md
# Multi-Digit Radix Carry Resolver

This block adds two numbers held as vectors of digits in a selectable radix. Each digit lane adds its two operand digits with no carry. It then classifies the raw sum as carry-generating (raw sum at or above the radix) or carry-propagating (raw sum exactly one below the radix). The generate and propagate flags of all lanes are packed into two bit vectors. A single binary addition over those vectors yields every inter-digit carry at once, so no carry ripples from lane to lane. Each lane then adds its incoming carry and wraps the result modulo the radix.

One operand pair is accepted per clock cycle when the input strobe is high. The result digits, the carry out of the top digit and a flag that marks the absence of any digit-to-digit carry are registered. They appear with an output strobe one cycle later. A caller can chain several blocks through carry-in and carry-out to handle wider numbers. The radix is a run-time input, so one instance serves decimal, binary or any other base up to the digit width.

Top module: `radix_carry_resolver`

## Requirements
- R1: Output digit i, at bits [i*DIGIT_W +: DIGIT_W] of sumDigits, equals (A[i] + B[i] + k[i]) mod radix, where k[i] is the carry into digit i, and operand digits use the same bit positions.
- R2: The carry into digit 0 is the carryIn input.
- R3: The carry into digit i+1 is 1 exactly when A[i] + B[i] + k[i] is at least the radix. Long runs of digits equal to radix-1 therefore pass a carry through in the same cycle.
- R4: carryOut is the carry leaving the most significant digit, computed by the rule of R3.
- R5: noProp is 1 exactly when no digit, the top one included, passes a carry to the next position. carryIn alone does not clear it.
- R6: A cycle with inValid high is answered by outValid high on the following cycle, with the result of that cycle's operands. outValid is low after any cycle with inValid low.
- R7: In a cycle after inValid was low, sumDigits, carryOut and noProp keep their previous values.
- R8: While rstN is low, outValid, sumDigits, carryOut and noProp are all 0.
- R9: Every radix from 2 to 2^DIGIT_W is supported, the top value included. Each result digit is below the radix, provided the operand digits are below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands on this cycle are to be added |
| aDigits | input | NUM_DIGITS*DIGIT_W | First operand, digit 0 least significant |
| bDigits | input | NUM_DIGITS*DIGIT_W | Second operand, same packing |
| radix | input | DIGIT_W+1 | Number base, 2 to 2^DIGIT_W |
| carryIn | input | 1 | Carry into digit 0 |
| outValid | output | 1 | Registered result is new this cycle |
| sumDigits | output | NUM_DIGITS*DIGIT_W | Result digits |
| carryOut | output | 1 | Carry out of the top digit |
| noProp | output | 1 | No digit passed a carry onward |

## Verification
The bench sweeps every operand pair and both carry-in values for each radix of a three-digit, two-bit configuration. This covers a carry rippling through a full chain of radix-1 digits, which a design that ignored propagate lanes or mis-shifted the carry vector would drop or place one digit off. The top radix 2^DIGIT_W exercises the raw-sum width: a lane one bit too narrow would miss generate flags and leave digits unwrapped. The sweep also includes carry-in against all-zero operands, where a flag that counted the injected carry would wrongly clear noProp. Each result is followed by an idle cycle, which exposes a register that reloads without a strobe.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  // Strobes driven by the control unit into the datapath.
  typedef struct packed {
    logic loadRes;   // capture the resolved sum this cycle
    logic clearRes;  // force result registers to zero
  } rcrCtrl_t;

endpackage

// File: rtl/rcr_digit_sense.sv
// One lane: raw digit sum and its generate / propagate classification.
module rcr_digit_sense #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  input  logic [DIGIT_W:0]   radix,
  output logic [DIGIT_W:0]   rawSum,
  output logic               gen,
  output logic               prop
);
  localparam int SUM_W = DIGIT_W + 1;

  logic [SUM_W-1:0] radixLess1;

  always_comb begin
    rawSum     = {1'b0, aDigit} + {1'b0, bDigit};
    radixLess1 = radix - SUM_W'(1);
    gen        = (rawSum >= radix);
    prop       = (rawSum == radixLess1);
  end
endmodule

// File: rtl/rcr_digit_fix.sv
// One lane: add the resolved incoming carry and wrap modulo the radix.
module rcr_digit_fix #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W:0]   rawSum,
  input  logic               carryInto,
  input  logic [DIGIT_W:0]   radix,
  output logic [DIGIT_W-1:0] digitOut
);
  localparam int SUM_W = DIGIT_W + 1;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    total    = rawSum + SUM_W'(carryInto);
    wrapped  = (total >= radix) ? (total - radix) : total;
    digitOut = wrapped[DIGIT_W-1:0];
  end
endmodule

// File: rtl/rcr_ctrl.sv
// Control: turns the input strobe and reset into datapath strobes and the output strobe.
module rcr_ctrl
  import rcr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output rcrCtrl_t ctrl,
  output logic     outValid
);
  logic validQ;

  always_comb begin
    ctrl.clearRes = !rstN;
    ctrl.loadRes  = rstN && inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;
endmodule

// File: rtl/rcr_datapath.sv
// Datapath: per-lane sensing, one-step carry resolution, per-lane fix-up, result registers.
module rcr_datapath
  import rcr_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  rcrCtrl_t                      ctrl,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] aDigits,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] bDigits,
  input  logic [DIGIT_W:0]              radix,
  input  logic                          carryIn,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sumDigits,
  output logic                          carryOut,
  output logic                          noProp
);
  localparam int VEC_W = NUM_DIGITS + 1;
  localparam int BUS_W = NUM_DIGITS * DIGIT_W;

  logic [DIGIT_W:0]      rawSum [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] genVec;
  logic [NUM_DIGITS-1:0] propVec;
  logic [VEC_W-1:0]      genWide;
  logic [VEC_W-1:0]      propWide;
  logic [VEC_W-1:0]      carryVec;
  logic [BUS_W-1:0]      sumNext;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sense
    rcr_digit_sense #(.DIGIT_W(DIGIT_W)) u_sense (
      .aDigit (aDigits[i*DIGIT_W +: DIGIT_W]),
      .bDigit (bDigits[i*DIGIT_W +: DIGIT_W]),
      .radix  (radix),
      .rawSum (rawSum[i]),
      .gen    (genVec[i]),
      .prop   (propVec[i])
    );
  end

  // carryVec[i] is the carry into digit i; carryVec[NUM_DIGITS] leaves the top digit.
  always_comb begin
    genWide  = {1'b0, genVec};
    propWide = {1'b0, propVec};
    carryVec = ((propWide | genWide) + genWide + VEC_W'(carryIn)) ^ propWide;
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_fix
    rcr_digit_fix #(.DIGIT_W(DIGIT_W)) u_fix (
      .rawSum    (rawSum[i]),
      .carryInto (carryVec[i]),
      .radix     (radix),
      .digitOut  (sumNext[i*DIGIT_W +: DIGIT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearRes) begin
      sumDigits <= '0;
      carryOut  <= 1'b0;
      noProp    <= 1'b0;
    end else if (ctrl.loadRes) begin
      sumDigits <= sumNext;
      carryOut  <= carryVec[NUM_DIGITS];
      noProp    <= ~|carryVec[NUM_DIGITS:1];
    end
  end
endmodule

// File: rtl/radix_carry_resolver.sv
module radix_carry_resolver
  import rcr_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] aDigits,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] bDigits,
  input  logic [DIGIT_W:0]              radix,
  input  logic                          carryIn,
  output logic                          outValid,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sumDigits,
  output logic                          carryOut,
  output logic                          noProp
);
  rcrCtrl_t ctrl;

  rcr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  rcr_datapath #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .aDigits   (aDigits),
    .bDigits   (bDigits),
    .radix     (radix),
    .carryIn   (carryIn),
    .sumDigits (sumDigits),
    .carryOut  (carryOut),
    .noProp    (noProp)
  );
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inValid,
  input logic [DIGIT_W:0]              radix,
  input logic                          outValid,
  input logic [NUM_DIGITS*DIGIT_W-1:0] sumDigits,
  input logic                          carryOut,
  input logic                          noProp
);
  function automatic logic allBelow(input logic [NUM_DIGITS*DIGIT_W-1:0] d,
                                    input logic [DIGIT_W:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if ({1'b0, d[i*DIGIT_W +: DIGIT_W]} >= r) ok = 1'b0;
    return ok;
  endfunction

  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sumDigits) && $stable(carryOut) && $stable(noProp)));

  // R5
  flag_vs_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && noProp) |-> !carryOut);

  // R9
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> allBelow(sumDigits, $past(radix)));
endmodule

bind radix_carry_resolver rcr_checker #(
  .NUM_DIGITS(NUM_DIGITS),
  .DIGIT_W   (DIGIT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .radix     (radix),
  .outValid  (outValid),
  .sumDigits (sumDigits),
  .carryOut  (carryOut),
  .noProp    (noProp)
);

// File: tb/sim_radix_carry_resolver.sv
`timescale 1ns/1ps
module sim_radix_carry_resolver;
  localparam int ND = 3;
  localparam int DW = 2;
  localparam int BW = ND * DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [BW-1:0] aDigits = '0;
  logic [BW-1:0] bDigits = '0;
  logic [DW:0]   radix = 3'd4;
  logic          carryIn = 1'b0;
  logic          outValid;
  logic [BW-1:0] sumDigits;
  logic          carryOut;
  logic          noProp;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  radix_carry_resolver #(.NUM_DIGITS(ND), .DIGIT_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aDigits(aDigits),
    .bDigits(bDigits), .radix(radix), .carryIn(carryIn), .outValid(outValid),
    .sumDigits(sumDigits), .carryOut(carryOut), .noProp(noProp)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply one operand set, check the result, then one idle cycle and check it holds.
  task automatic runVec(input int r, input int aVal, input int bVal, input int cin);
    int expSum, c, ds, anyCarry;
    logic [BW-1:0] aP, bP;
    aP = '0; bP = '0; expSum = 0; c = cin; anyCarry = 0;
    for (int i = 0; i < ND; i++) begin
      int ad, bd, p;
      p  = r ** i;
      ad = (aVal / p) % r;
      bd = (bVal / p) % r;
      aP[i*DW +: DW] = DW'(ad);
      bP[i*DW +: DW] = DW'(bd);
      ds = ad + bd + c;
      c  = (ds >= r) ? 1 : 0;
      if (c) anyCarry = 1;
      expSum = expSum + ((ds % r) << (i*DW));
    end
    @(negedge clk);
    radix = (DW+1)'(r); aDigits = aP; bDigits = bP; carryIn = 1'(cin); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 outValid", int'(outValid), 1);
    check("R1/R2/R3/R9 digits", int'(sumDigits), expSum);
    check("R4 carryOut", int'(carryOut), c);
    check("R5 noProp", int'(noProp), anyCarry ? 0 : 1);
    aDigits = ~aP; bDigits = ~bP; carryIn = ~carryIn;
    @(negedge clk);
    check("R6 idle outValid", int'(outValid), 0);
    check("R7 hold digits", int'(sumDigits), expSum);
    check("R7 hold carryOut", int'(carryOut), c);
    check("R7 hold noProp", int'(noProp), anyCarry ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    inValid = 1'b1; aDigits = '1; bDigits = '1; carryIn = 1'b1;
    @(negedge clk);
    check("R8 reset outValid", int'(outValid), 0);
    check("R8 reset digits", int'(sumDigits), 0);
    check("R8 reset carryOut", int'(carryOut), 0);
    check("R8 reset noProp", int'(noProp), 0);
    inValid = 1'b0;
    rstN = 1'b1;
    for (int r = 2; r <= (1 << DW); r++) begin
      int span;
      span = r ** ND;
      for (int a = 0; a < span; a++)
        for (int b = 0; b < span; b++)
          for (int ci = 0; ci < 2; ci++)
            runVec(r, a, b, ci);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule